// File: doc/BRIEF.md
# Line Transmit Framer and Scrambler

This block produces the 160 kb/s transmit bit stream of a four-level basic-rate line interface, one line bit per pulse of `bit_en` (160 kHz), grouped into two-bit symbols at 80 kbaud. Each 240-bit frame opens with an 18-bit synchronization word. Next come 216 bits of rate-adapted 2B+D payload taken from a ready/valid bit port, then 6 overhead bits. The overhead bits carry maintenance/control values taken from a register port and a 12-bit CRC. Eight frames make one superframe.

Payload and overhead bits pass through a self-synchronizing scrambler before they are sent. The synchronization word is inserted after the scrambler and bypasses it. The CRC is taken over one superframe's payload and maintenance bits and is sent in the overhead of the next superframe. When the payload source has no bit ready, the block sends a ones fill bit and sets a sticky underrun flag.

A three-state machine orders each frame. `ST_SYNC` goes to `ST_PAYLOAD` on transition T_SYNC_DONE, after frame bit 17. `ST_PAYLOAD` goes to `ST_OVERHEAD` on T_PAY_DONE, after frame bit 233. `ST_OVERHEAD` returns to `ST_SYNC` on T_FRAME_DONE, after frame bit 239. T_FRAME_DONE also advances the frame number, which wraps from 7 to 0. State changes happen only on an enabled bit.

Top module: `line_tx_framer`

## Requirements
- R1: A frame is 240 enabled bits. Frame bits 0-17 are sync, 18-233 are payload and 234-239 are overhead. `pay_ready` is high exactly when `bit_en` is high during a payload bit. Reset starts at frame 0, bit 0.
- R2: The sync bits are 101000000010001010, first bit first, and are never scrambled. Each symbol is {first bit, second bit}: 10 = +3, 11 = +1, 01 = -1, 00 = -3, so the word reads +3 +3 -3 -3 -3 +3 -3 +3 +3.
- R3: Every payload and overhead bit d is sent as s = d XOR s5 XOR s23. Here sk is the scrambled bit sent k scrambled bits earlier. Sync bits do not advance this history. The history is all zeros after reset and is never cleared at frame boundaries.
- R4: A payload bit is taken when `pay_ready` and `pay_valid` are both high, and payload bits are sent in the order they are taken.
- R5: If `pay_valid` is low during a payload bit, a 1 is sent in its place. `underrun` then goes high on the next clock and stays high until reset.
- R6: `maint_word` is sampled on frame bit 0. Later changes in the same frame have no effect. In frames 0-5 the overhead is maint[5], maint[4], maint[3], maint[2] followed by two CRC bits. In frames 6-7 it is maint[5] down to maint[0].
- R7: The CRC is 12 bits, with polynomial x^12+x^11+x^3+x^2+x+1, MSB-first shifting and a zero start value. It covers the unscrambled payload bits, fill included, and the maintenance bits of one superframe. Frame f (0-5) of the next superframe carries CRC bits 11-2f and then 10-2f. The first superframe after reset carries zeros.
- R8: `sym_valid` pulses for one cycle, the cycle after the clock edge that consumes the second bit of a pair. At that time `sym_out` = {first bit, second bit}.
- R9: `frame_start` is high with the first symbol of every frame. `sframe_start` is high with the first symbol of frame 0 only. Both are low at all other times.
- R10: After reset, `sym_valid`, `frame_start`, `sframe_start` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | One pulse per line bit period |
| pay_valid | input | 1 | Payload bit offered |
| pay_data | input | 1 | Payload bit value |
| pay_ready | output | 1 | Payload bit taken this cycle if valid |
| maint_word | input | 6 | Maintenance/control bits for the next frame |
| sym_out | output | 2 | Symbol {first, second line bit} |
| sym_valid | output | 1 | `sym_out` is new this cycle |
| frame_start | output | 1 | First symbol of a frame |
| sframe_start | output | 1 | First symbol of a superframe |
| underrun | output | 1 | Sticky payload starvation flag |

## Verification
The bench runs three full superframes and compares every symbol against a model that applies the requirements bit by bit. The second and third superframes therefore carry nonzero CRCs. A design that clears the CRC at the wrong bit, or leaves out the last maintenance bit of frame 7, sends a wrong CRC pair in the following superframe.

Scrambler history carries across frames. A design that shifts its history during sync bits, or clears it at each frame start, corrupts the symbols just after the sync word.

`maint_word` is rewritten in the middle of every frame. A design that does not hold its frame-start sample emits the rewritten value in the overhead.

Payload starvation windows check three things: that a 1 is sent in place of each missing bit, that the flag stays set, and that no payload bit is lost or repeated. A slip in the payload count would shift every later payload bit.

// File: rtl/line_tx_pkg.sv
package line_tx_pkg;

    typedef enum logic [1:0] {
        ST_SYNC     = 2'd0,
        ST_PAYLOAD  = 2'd1,
        ST_OVERHEAD = 2'd2
    } frm_state_t;

endpackage

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
    import line_tx_pkg::*;
#(
    parameter int SYNC_BITS = 18,
    parameter int PAY_BITS  = 216,
    parameter int OH_BITS   = 6,
    parameter int SF_FRAMES = 8,
    localparam int FRAME_BITS = SYNC_BITS + PAY_BITS + OH_BITS,
    localparam int PW = $clog2(FRAME_BITS),
    localparam int FW = $clog2(SF_FRAMES),
    localparam int OW = $clog2(OH_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    output frm_state_t    state,
    output logic [PW-1:0] fpos,
    output logic [FW-1:0] frame,
    output logic [OW-1:0] oh_idx,
    output logic          in_sync,
    output logic          in_pay,
    output logic          in_oh,
    output logic          sf_last
);

    localparam logic [PW-1:0] SYNC_LAST  = PW'(SYNC_BITS - 1);
    localparam logic [PW-1:0] PAY_LAST   = PW'(SYNC_BITS + PAY_BITS - 1);
    localparam logic [PW-1:0] OH_START   = PW'(SYNC_BITS + PAY_BITS);
    localparam logic [PW-1:0] FRAME_LAST = PW'(FRAME_BITS - 1);
    localparam logic [FW-1:0] SF_LAST    = FW'(SF_FRAMES - 1);

    frm_state_t state_nx;
    logic       frame_done;

    assign frame_done = bit_en && (fpos == FRAME_LAST);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SYNC:     if (bit_en && fpos == SYNC_LAST) state_nx = ST_PAYLOAD;   // T_SYNC_DONE
            ST_PAYLOAD:  if (bit_en && fpos == PAY_LAST)  state_nx = ST_OVERHEAD;  // T_PAY_DONE
            ST_OVERHEAD: if (frame_done)                  state_nx = ST_SYNC;      // T_FRAME_DONE
            default:                                      state_nx = ST_SYNC;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SYNC;
        else        state <= state_nx;
    end

    // bit position and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fpos  <= '0;
            frame <= '0;
        end else if (bit_en) begin
            fpos <= frame_done ? '0 : fpos + 1'b1;
            if (frame_done) frame <= (frame == SF_LAST) ? '0 : frame + 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        in_sync = 1'b0;
        in_pay  = 1'b0;
        in_oh   = 1'b0;
        unique case (state)
            ST_SYNC:     in_sync = 1'b1;
            ST_PAYLOAD:  in_pay  = 1'b1;
            ST_OVERHEAD: in_oh   = 1'b1;
            default:     in_sync = 1'b1;
        endcase
        oh_idx  = OW'(fpos - OH_START);
        sf_last = in_oh && (fpos == FRAME_LAST) && (frame == SF_LAST);
    end

    AST_SYNC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC) |-> (fpos <= SYNC_LAST)) else $error("sync out of range"); // R1
    AST_PAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAYLOAD) |-> (fpos > SYNC_LAST && fpos <= PAY_LAST)) else $error("payload out of range"); // R1
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (fpos == '0 && state == ST_SYNC)) else $error("frame wrap"); // R1

endmodule

// File: rtl/tx_scrambler.sv
module tx_scrambler #(
    parameter int TAP_A = 5,
    parameter int TAP_B = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);

    logic [TAP_B-1:0] hist;

    assign dout = din ^ hist[TAP_A-1] ^ hist[TAP_B-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  hist <= '0;
        else if (en) hist <= {hist[TAP_B-2:0], dout};
    end

    AST_SCR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(hist)) else $error("scrambler moved"); // R3

endmodule

// File: rtl/tx_crc.sv
module tx_crc #(
    parameter int          W    = 12,
    parameter logic [W-1:0] POLY = 12'h80F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    input  logic         sf_end,
    output logic [W-1:0] crc_tx
);

    logic [W-1:0] acc;
    logic [W-1:0] acc_nx;

    always_comb begin
        acc_nx = {acc[W-2:0], 1'b0} ^ ({W{din ^ acc[W-1]}} & POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            crc_tx <= '0;
        end else if (sf_end) begin
            crc_tx <= en ? acc_nx : acc;
            acc    <= '0;
        end else if (en) begin
            acc <= acc_nx;
        end
    end

    AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sf_end |=> (acc == '0)) else $error("crc not cleared"); // R7
    AST_CRC_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_end |=> $stable(crc_tx)) else $error("crc tx changed"); // R7

endmodule

// File: rtl/line_tx_framer.sv
module line_tx_framer
    import line_tx_pkg::*;
#(
    parameter int               SYNC_BITS = 18,
    parameter int               PAY_BITS  = 216,
    parameter int               OH_BITS   = 6,
    parameter int               SF_FRAMES = 8,
    parameter int               CRC_W     = 12,
    parameter logic [CRC_W-1:0] CRC_POLY  = 12'h80F,
    parameter int               SCR_TAP_A = 5,
    parameter int               SCR_TAP_B = 23,
    parameter logic [SYNC_BITS-1:0] SYNC_WORD = 18'b101000000010001010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               pay_valid,
    input  logic               pay_data,
    output logic               pay_ready,
    input  logic [OH_BITS-1:0] maint_word,
    output logic [1:0]         sym_out,
    output logic               sym_valid,
    output logic               frame_start,
    output logic               sframe_start,
    output logic               underrun
);

    localparam int FRAME_BITS = SYNC_BITS + PAY_BITS + OH_BITS;
    localparam int PW         = $clog2(FRAME_BITS);
    localparam int FW         = $clog2(SF_FRAMES);
    localparam int OW         = $clog2(OH_BITS);
    localparam int SYW        = $clog2(SYNC_BITS);
    localparam int CIW        = $clog2(CRC_W);
    localparam int CRC_FRAMES = CRC_W / 2;
    localparam int CRC_SLOT0  = OH_BITS - 2;

    frm_state_t       state;
    logic [PW-1:0]    fpos;
    logic [FW-1:0]    frame;
    logic [OW-1:0]    oh_idx;
    logic             in_sync, in_pay, in_oh, sf_last;
    logic [OH_BITS-1:0] maint_snap;
    logic [CRC_W-1:0] crc_tx;
    logic             oh_is_crc;
    logic             raw_bit, scr_bit, line_bit, hi_bit;
    logic             crc_en, scr_en;

    tx_frame_seq #(
        .SYNC_BITS(SYNC_BITS), .PAY_BITS(PAY_BITS),
        .OH_BITS(OH_BITS),     .SF_FRAMES(SF_FRAMES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .state(state), .fpos(fpos), .frame(frame), .oh_idx(oh_idx),
        .in_sync(in_sync), .in_pay(in_pay), .in_oh(in_oh), .sf_last(sf_last)
    );

    assign pay_ready = bit_en && in_pay;

    // unscrambled bit selection
    always_comb begin
        int ci;
        ci        = 0;
        oh_is_crc = in_oh && (int'(frame) < CRC_FRAMES) && (int'(oh_idx) >= CRC_SLOT0);
        raw_bit   = 1'b1;
        if (in_pay) begin
            raw_bit = pay_valid ? pay_data : 1'b1;
        end else if (oh_is_crc) begin
            ci      = CRC_W - 1 - (2 * int'(frame) + int'(oh_idx) - CRC_SLOT0);
            raw_bit = crc_tx[CIW'(ci)];
        end else if (in_oh) begin
            raw_bit = maint_snap[OW'(OH_BITS - 1) - oh_idx];
        end
    end

    assign crc_en = bit_en && (in_pay || (in_oh && !oh_is_crc));
    assign scr_en = bit_en && !in_sync;

    tx_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .en(crc_en), .din(raw_bit),
        .sf_end(bit_en && sf_last), .crc_tx(crc_tx)
    );

    tx_scrambler #(.TAP_A(SCR_TAP_A), .TAP_B(SCR_TAP_B)) u_scr (
        .clk(clk), .rst_n(rst_n), .en(scr_en), .din(raw_bit), .dout(scr_bit)
    );

    assign line_bit = in_sync ? SYNC_WORD[SYW'(SYNC_BITS - 1) - fpos[SYW-1:0]] : scr_bit;

    // maintenance snapshot at frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      maint_snap <= '0;
        else if (bit_en && fpos == '0)   maint_snap <= maint_word;
    end

    // sticky underrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          underrun <= 1'b0;
        else if (pay_ready && !pay_valid)    underrun <= 1'b1;
    end

    // symbol assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_bit       <= 1'b0;
            sym_out      <= 2'b00;
            sym_valid    <= 1'b0;
            frame_start  <= 1'b0;
            sframe_start <= 1'b0;
        end else begin
            sym_valid    <= 1'b0;
            frame_start  <= 1'b0;
            sframe_start <= 1'b0;
            if (bit_en) begin
                if (!fpos[0]) begin
                    hi_bit <= line_bit;
                end else begin
                    sym_out      <= {hi_bit, line_bit};
                    sym_valid    <= 1'b1;
                    frame_start  <= (fpos == PW'(1));
                    sframe_start <= (fpos == PW'(1)) && (frame == '0);
                end
            end
        end
    end

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun) else $error("underrun cleared"); // R5
    AST_SYM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid) else $error("valid too long"); // R8
    AST_FRAME_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> sym_valid) else $error("frame strobe alone"); // R9
    AST_SF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sframe_start |-> frame_start) else $error("superframe strobe alone"); // R9
    AST_SYNC_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (sym_out == SYNC_WORD[SYNC_BITS-1 -: 2])) else $error("bad sync head"); // R2

endmodule

// File: tb/test_line_tx_framer.sv
module test_line_tx_framer;

    localparam int CLK_PERIOD = 10;
    localparam int NBITS      = 3 * 8 * 240;
    localparam logic [17:0] SYNC = 18'b101000000010001010;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       pay_valid = 1'b0;
    logic       pay_data = 1'b0;
    logic [5:0] maint_word = '0;
    logic       pay_ready;
    logic [1:0] sym_out;
    logic       sym_valid, frame_start, sframe_start, underrun;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_tx_framer i_line_tx_framer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
        .maint_word(maint_word), .sym_out(sym_out), .sym_valid(sym_valid),
        .frame_start(frame_start), .sframe_start(sframe_start), .underrun(underrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic vld(input int n);
        return !((n >= 1000 && n < 1005) || (n >= 2500 && (n % 97) == 50));
    endfunction

    function automatic logic pdat(input int c);
        return c[0] ^ c[3] ^ ((c % 5) == 0);
    endfunction

    function automatic logic [5:0] mval(input int fg);
        return 6'((fg * 13 + 5) & 63);
    endfunction

    function automatic logic [11:0] crc_step(input logic [11:0] a, input logic b);
        return {a[10:0], 1'b0} ^ ({12{b ^ a[11]}} & 12'h80F);
    endfunction

    // model state
    logic [22:0] m_scr = '0;
    logic [11:0] m_acc = '0;
    logic [11:0] m_tx  = '0;
    logic [5:0]  m_snap = '0;
    logic        m_und = 1'b0;
    logic        m_hi  = 1'b0;
    int          acc_cnt = 0;

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", sym_valid, 0);
        chk("R10", frame_start, 0);
        chk("R10", sframe_start, 0);
        chk("R10", underrun, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", pay_ready, 0);
        chk("R10", sym_valid, 0);

        for (int n = 0; n < NBITS; n++) begin
            int p, fg, f, k;
            logic raw, lb, s;
            string lbl;
            p  = n % 240;
            fg = n / 240;
            f  = fg % 8;
            @(negedge clk);
            bit_en    = 1'b1;
            pay_valid = vld(n);
            pay_data  = pdat(acc_cnt);
            if (p == 0) maint_word = mval(fg);
            #1;
            chk("R1", pay_ready, (p >= 18 && p < 234));

            // model
            if (p == 0) m_snap = maint_word;
            if (p < 18) begin
                lb  = SYNC[17 - p];
                lbl = "R2";
            end else begin
                if (p < 234) begin
                    if (pay_valid) begin raw = pay_data; acc_cnt++; end
                    else begin raw = 1'b1; m_und = 1'b1; end
                    m_acc = crc_step(m_acc, raw);
                    lbl = "R3 R4";
                end else begin
                    k = p - 234;
                    if (f < 6 && k >= 4) begin
                        raw = m_tx[11 - (2 * f + k - 4)];
                        lbl = "R7";
                    end else begin
                        raw   = m_snap[5 - k];
                        m_acc = crc_step(m_acc, raw);
                        lbl = "R6";
                    end
                end
                s     = raw ^ m_scr[4] ^ m_scr[22];
                m_scr = {m_scr[21:0], s};
                lb    = s;
                if (p == 239 && f == 7) begin
                    m_tx  = m_acc;
                    m_acc = '0;
                end
            end

            @(negedge clk);
            bit_en = 1'b0;
            #1;
            chk("R5", underrun, m_und);
            if (p % 2 == 0) begin
                m_hi = lb;
                chk("R8", sym_valid, 0);
            end else begin
                chk("R8", sym_valid, 1);
                chk(lbl, sym_out, {m_hi, lb});
                chk("R9", frame_start, (p == 1));
                chk("R9", sframe_start, (p == 1 && f == 0));
            end

            @(negedge clk);
            #1;
            chk("R1", pay_ready, 0);
            chk("R8", sym_valid, 0);
            if (p == 100) maint_word = ~mval(fg);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule